// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block models the device side of a small flash array. It programs one 16-bit word at a time, and it erases either one sector or the whole array. Commands arrive on a valid/ready command port. Each command is an opcode, a word address and a data word. The block stores the words itself and applies the rule that programming can only clear bits. An erased bit reads as 1.

An operation runs for a programmable number of cycles. A separate timeout limit ends the operation early with a failure. While an operation runs, or after it has failed, some reads return a status word instead of array data. These are reads of the word being programmed, or reads of an even address inside the range being erased.

The status word carries two fields, each copied into both bytes:
- A polling field on bits 15 and 7. During a program it holds the complement of the matching data bits. During an erase it reads 0.
- An error field on bits 13 and 5.

A `busy` pin gives a third way to see completion. An error stays set until a reset command clears it.

Top module: `flash_stat_gen`

## Requirements
- R1: Opcode 0 (program) accepted while idle raises `busy` on the next cycle and keeps it high for `op_len` cycles. If no error occurs, the addressed word then holds the old word ANDed with `cmd_data`.
- R2: While a program runs, a read of the target address returns a status word. Bit 15 holds the inverse of data bit 15, bit 7 holds the inverse of data bit 7, and all other bits are 0. Reads of any other address return array contents.
- R3: Opcode 1 (sector erase) sets to 16'hFFFF every word whose top `SECT_W` address bits match those of `cmd_addr`. Words in other sectors are unchanged.
- R4: Opcode 2 (full erase) sets every word to 16'hFFFF, whatever `cmd_addr` holds.
- R5: During an erase, a read of an even address inside the erased range returns a status word with bits 15 and 7 at 0. A read of an odd address, or of an address outside the range, returns array contents.
- R6: A program whose data has a 1 where the old word has a 0 runs its full length and then fails. The word is left unchanged, and the status word has bits 13 and 5 set.
- R7: When an operation has run `tout_len` cycles before reaching `op_len`, it ends in the failed state after `tout_len` busy cycles. Timeout wins a tie, and the array is left unchanged.
- R8: In the failed state:
  - `busy` is low.
  - Status keeps being returned on the target reads.
  - Program and erase commands are ignored.
  - Only opcode 3 (reset) returns the block to normal reads.
- R9: Program and erase commands presented while `busy` is high are ignored and do not change the run length. Opcode 3 is ignored outside the failed state.
- R10: `cmd_ready` is always 1, so every command completes its handshake on the cycle it is presented. After reset, `busy` is 0 and every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 full erase, 3 reset |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | 16 | Data to program |
| op_len | input | CNT_W | Run length of an operation, in cycles |
| tout_len | input | CNT_W | Timeout limit, in cycles |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 16 | Array word or status word, combinational from `rd_addr` |
| busy | output | 1 | High while an operation runs |

## Verification
A command is sampled on the rising edge where `cmd_valid` is high. `busy` goes high right after that edge and falls after `op_len` edges, or after `tout_len` edges on a timeout. The array update, or the failed state, is visible from the same edge on which `busy` falls. `rd_data` follows `rd_addr` in the same cycle, with no register between them. The bench therefore drives inputs and samples outputs on the falling edge. It counts busy cycles one falling edge at a time, and it reads status or array words half a cycle after setting the address.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ESECT = 2'd1,
    OP_EALL  = 2'd2,
    OP_RST   = 2'd3
  } fsg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ERR  = 2'd2
  } fsg_st_e;

  localparam int WORD_W = 16;
  localparam int POLL_HI = 15;
  localparam int POLL_LO = 7;
  localparam int FAIL_HI = 13;
  localparam int FAIL_LO = 5;

  function automatic logic [WORD_W-1:0] stat_word(input logic is_prog,
                                                  input logic [WORD_W-1:0] d,
                                                  input logic failed);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POLL_HI] = is_prog & ~d[POLL_HI];
    w[POLL_LO] = is_prog & ~d[POLL_LO];
    w[FAIL_HI] = failed;
    w[FAIL_LO] = failed;
    return w;
  endfunction
endpackage

// File: rtl/fsg_seq.sv
module fsg_seq
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  fsg_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [CNT_W-1:0]  op_len,
  input  logic [CNT_W-1:0]  tout_len,
  input  logic [WORD_W-1:0] old_word,
  output logic              busy,
  output logic              failed,
  output fsg_op_e           tgt_op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_data,
  output logic              do_prog,
  output logic              do_esect,
  output logic              do_eall
);
  fsg_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic accept, clear, tout_hit, len_hit, viol, done_ok;

  assign accept   = cmd_valid && st_q == ST_IDLE && cmd_op != OP_RST;
  assign clear    = cmd_valid && st_q == ST_ERR && cmd_op == OP_RST;
  assign tout_hit = st_q == ST_BUSY && cnt_q >= tout_len;
  assign len_hit  = st_q == ST_BUSY && !tout_hit && cnt_q >= op_len;
  assign viol     = tgt_op == OP_PROG && |(tgt_data & ~old_word);
  assign done_ok  = len_hit && !viol;
  assign do_prog  = done_ok && tgt_op == OP_PROG;
  assign do_esect = done_ok && tgt_op == OP_ESECT;
  assign do_eall  = done_ok && tgt_op == OP_EALL;
  assign busy     = st_q == ST_BUSY;
  assign failed   = st_q == ST_ERR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      tgt_op   <= OP_PROG;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q     <= ST_BUSY;
          cnt_q    <= CNT_W'(1);
          tgt_op   <= cmd_op;
          tgt_addr <= cmd_addr;
          tgt_data <= cmd_data;
        end
        ST_BUSY: begin
          if (tout_hit || (len_hit && viol)) st_q <= ST_ERR;
          else if (len_hit)                  st_q <= ST_IDLE;
          else                               cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_ERR: if (clear) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !(cmd_valid && cmd_op == OP_RST)) |=> failed);
  // R8
  err_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && failed));
  // R7
  tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q >= tout_len) |=> failed);
  // R9
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tgt_addr) && $stable(tgt_data)));
endmodule

// File: rtl/fsg_array.sv
module fsg_array
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [WORD_W-1:0] tgt_data,
  output logic [WORD_W-1:0] tgt_word,
  input  logic              do_prog,
  input  logic              do_esect,
  input  logic              do_eall
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  assign rd_word  = mem[rd_addr];
  assign tgt_word = mem[tgt_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (do_eall) mem[i] <= '1;
        else if (do_esect &&
                 ADDR_W'(i) >> (ADDR_W - SECT_W) == tgt_addr >> (ADDR_W - SECT_W))
          mem[i] <= '1;
        else if (do_prog && ADDR_W'(i) == tgt_addr)
          mem[i] <= mem[i] & tgt_data;
      end
    end
  end

  // R1
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> (tgt_word & ~$past(tgt_word)) == '0);
endmodule

// File: rtl/fsg_rdmux.sv
module fsg_rdmux
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              failed,
  input  fsg_op_e           tgt_op,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [WORD_W-1:0] tgt_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] arr_word,
  output logic [WORD_W-1:0] rd_data
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic hit, same_sect;

  assign same_sect = rd_addr[ADDR_W-1:SECT_LSB] == tgt_addr[ADDR_W-1:SECT_LSB];

  always_comb begin
    case (tgt_op)
      OP_PROG:  hit = rd_addr == tgt_addr;
      OP_ESECT: hit = !rd_addr[0] && same_sect;
      OP_EALL:  hit = !rd_addr[0];
      default:  hit = 1'b0;
    endcase
  end

  assign rd_data = ((busy || failed) && hit)
                   ? stat_word(tgt_op == OP_PROG, tgt_data, failed)
                   : arr_word;

  // R5
  erase_poll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tgt_op != OP_PROG && !rd_addr[0] && (tgt_op == OP_EALL || same_sect))
      |-> (!rd_data[POLL_HI] && !rd_data[POLL_LO]));
endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  input  logic [CNT_W-1:0]  op_len,
  input  logic [CNT_W-1:0]  tout_len,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy
);
  fsg_op_e           tgt_op;
  logic [ADDR_W-1:0] tgt_addr;
  logic [WORD_W-1:0] tgt_data, tgt_word, arr_word;
  logic              failed, do_prog, do_esect, do_eall;

  assign cmd_ready = 1'b1;

  fsg_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(fsg_op_e'(cmd_op)),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .op_len(op_len), .tout_len(tout_len),
    .old_word(tgt_word), .busy(busy), .failed(failed), .tgt_op(tgt_op),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .do_prog(do_prog),
    .do_esect(do_esect), .do_eall(do_eall)
  );

  fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_word(arr_word),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .tgt_word(tgt_word),
    .do_prog(do_prog), .do_esect(do_esect), .do_eall(do_eall)
  );

  fsg_rdmux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) mux_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .failed(failed), .tgt_op(tgt_op),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .rd_addr(rd_addr),
    .arr_word(arr_word), .rd_data(rd_data)
  );
endmodule

// File: tb/flash_stat_gen_tb.sv
module flash_stat_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [4:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [7:0] op_len = 8'd4;
  logic [7:0] tout_len = 8'd20;
  logic [4:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic       busy;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_stat_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .op_len(op_len),
    .tout_len(tout_len), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [15:0] data;
    logic [15:0] fin;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 5'd3,  16'h1234, 16'h1234},
    '{2'd0, 5'd3,  16'h1030, 16'h1030},
    '{2'd0, 5'd9,  16'hA5F0, 16'hA5F0},
    '{2'd1, 5'd2,  16'h0000, 16'hFFFF},
    '{2'd0, 5'd20, 16'h00FF, 16'h00FF},
    '{2'd2, 5'd20, 16'h0000, 16'hFFFF}
  };

  function automatic logic [15:0] exp_stat(input logic prog, input logic [15:0] d,
                                           input logic e);
    logic [15:0] w;
    w = '0;
    w[15] = prog & ~d[15];
    w[7]  = prog & ~d[7];
    w[13] = e;
    w[5]  = e;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] a, input logic [15:0] d);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 ready", {31'd0, cmd_ready}, 32'd1);
    rd(5'd0, v);  check("R10 word0", {16'd0, v}, 32'hFFFF);
    rd(5'd31, v); check("R10 word31", {16'd0, v}, 32'hFFFF);

    // Table: R1 R2 R3 R4 R5
    for (int k = 0; k < 6; k++) begin
      issue(VEC[k].op, VEC[k].addr, VEC[k].data);
      rd(VEC[k].addr, v);
      check("R2/R5 mid status", {16'd0, v},
            {16'd0, exp_stat(VEC[k].op == 2'd0, VEC[k].data, 1'b0)});
      count_busy(n);
      check("R1 busy length", n, 32'd4);
      rd(VEC[k].addr, v);
      check("R1/R3/R4 final word", {16'd0, v}, {16'd0, VEC[k].fin});
      if (k == 3) begin
        rd(5'd3, v); check("R3 in sector", {16'd0, v}, 32'hFFFF);
        rd(5'd9, v); check("R3 other sector", {16'd0, v}, 32'hA5F0);
      end
    end
    rd(5'd9, v); check("R4 all erased", {16'd0, v}, 32'hFFFF);

    // R5 odd and out-of-range reads during a sector erase
    issue(2'd1, 5'd8, 16'h0);
    rd(5'd10, v); check("R5 even in sector", {16'd0, v}, 32'h0000);
    rd(5'd11, v); check("R5 odd in sector", {16'd0, v}, 32'hFFFF);
    rd(5'd0, v);  check("R5 outside sector", {16'd0, v}, 32'hFFFF);
    count_busy(n);

    // R2 other address during program
    issue(2'd0, 5'd4, 16'h0F0F);
    rd(5'd4, v); check("R2 target", {16'd0, v}, 32'h8080);
    rd(5'd5, v); check("R2 other addr", {16'd0, v}, 32'hFFFF);
    count_busy(n);
    rd(5'd4, v); check("R1 programmed", {16'd0, v}, 32'h0F0F);

    // R6 attempt to set cleared bits
    issue(2'd0, 5'd4, 16'hF0F0);
    count_busy(n);
    check("R6 run length", n, 32'd4);
    rd(5'd4, v); check("R6 fail status", {16'd0, v}, 32'h2020);

    // R8 sticky failed state
    issue(2'd0, 5'd6, 16'h0000);
    check("R8 busy low", {31'd0, busy}, 32'd0);
    rd(5'd6, v); check("R8 cmd ignored", {16'd0, v}, 32'hFFFF);
    rd(5'd4, v); check("R8 status kept", {16'd0, v}, 32'h2020);
    issue(2'd3, 5'd0, 16'h0);
    rd(5'd4, v); check("R8/R6 after reset cmd", {16'd0, v}, 32'h0F0F);

    // R7 timeout
    op_len = 8'd10; tout_len = 8'd3;
    issue(2'd0, 5'd8, 16'h1111);
    count_busy(n);
    check("R7 timeout length", n, 32'd3);
    rd(5'd8, v); check("R7 timeout status", {16'd0, v}, 32'hA0A0);
    issue(2'd3, 5'd0, 16'h0);
    rd(5'd8, v); check("R7 array unchanged", {16'd0, v}, 32'hFFFF);
    op_len = 8'd4; tout_len = 8'd20;

    // R9 commands ignored while busy
    issue(2'd0, 5'd10, 16'h0000);
    issue(2'd2, 5'd0, 16'h0);
    count_busy(n);
    check("R9 remaining length", n, 32'd3);
    @(negedge clk);
    check("R9 no restart", {31'd0, busy}, 32'd0);
    rd(5'd10, v); check("R9 word kept", {16'd0, v}, 32'h0000);
    issue(2'd3, 5'd0, 16'h0);
    check("R9 reset cmd idle", {31'd0, busy}, 32'd0);
    rd(5'd10, v); check("R9 reset no effect", {16'd0, v}, 32'h0000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule